// File: doc/BRIEF.md
# Serial Frame Transmitter with Break

This block turns parallel words into an asynchronous serial bit stream. Each data frame has a low start bit, then 8 or 9 data bits with the least significant bit first, then a high stop bit. When parity is enabled, the last data position carries an even or odd parity bit in place of data. The transmitter can also send an idle frame, which is high for one whole frame length. It can also send break frames, which hold the line low for whole frame lengths. After the last break frame it sends one extra high bit, so a receiver can find the next start bit.

The bit clock comes from a built-in tick generator. An extended prescaler and a divisor are chained, so one bit lasts (prescaler+1)*(divisor+1) clock cycles. The generator is held cleared while the transmitter is idle and starts on the cycle after a frame begins. The word length and the parity selection are captured when a frame begins. A word is loaded with a one-cycle load strobe while `busy_o` is low.

The state machine has five states. S_IDLE drives the line high. S_START covers the start position, S_DATA the data positions, S_STOP the stop position, and S_MARK the extra high bit after a break. The transitions are:
- S_IDLE goes to S_START when a break request, an idle request or a load is seen.
- S_START goes to S_DATA on a tick.
- S_DATA goes to S_STOP on the tick that ends the last data position.
- S_STOP goes back to S_START on a tick if this is a break frame and the break request is still high.
- S_STOP otherwise goes to S_MARK on a tick if this is a break frame, or to S_IDLE on a tick for any other frame.
- S_MARK goes to S_IDLE on a tick.

Top module: `sertx_top`

## Requirements
- R1: Out of reset, and whenever no frame is in progress, `txd_o` is 1 and `busy_o` is 0.
- R2: A load accepted in idle sends a data frame: start 0, then data bits LSB first, then stop 1. There are 8 data bits (`data_i[7:0]`) when `len9_i`=0 and 9 data bits (`data_i[8:0]`) when `len9_i`=1. The data and all mode inputs are captured at the accepting edge, so later changes to them do not affect the frame.
- R3: With `par_en_i`=1, the last data position (bit 7 in 8-bit mode, bit 8 in 9-bit mode) carries the parity bit. This bit is the XOR of the preceding data bits when `par_odd_i`=0, and its inverse when `par_odd_i`=1.
- R4: Every bit position lasts exactly (`pre_div_i`+1)*(`baud_div_i`+1) clock cycles. The start position begins on the first cycle after the accepting edge.
- R5: A request on `idle_req_i` in idle sends one idle frame. The line stays 1 for 10 bit times (8-bit mode) or 11 bit times (9-bit mode), with `busy_o`=1.
- R6: A request on `brk_req_i` in idle sends break frames, with the line 0 for full frame lengths. Another break frame follows as long as the request is still high when a break frame ends.
- R7: When the request is low at the end of a break frame, the line is 1 for exactly one extra bit time with `busy_o`=1. The block then returns to idle.
- R8: `busy_o` rises on the cycle after a frame begins and falls on the cycle after its last position (the stop bit or the extra high bit). A load while `busy_o`=1 is ignored and is not queued.
- R9: When requests coincide in idle, break wins over idle, and idle wins over load. The losing requests are dropped.
- R10: While a frame is in progress, `txd_o` changes only at bit boundaries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Load strobe for a data frame |
| data_i | input | 9 | Data word |
| len9_i | input | 1 | 1 = 9 data bits, 0 = 8 data bits |
| par_en_i | input | 1 | Parity replaces the last data position |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| idle_req_i | input | 1 | Request an idle frame |
| brk_req_i | input | 1 | Request break frames (level) |
| pre_div_i | input | PRE_W | Extended prescaler value (period minus one) |
| baud_div_i | input | DIV_W | Divisor value (period minus one) |
| busy_o | output | 1 | Frame in progress |
| txd_o | output | 1 | Serial line |

## Verification
On every cycle, the assertions check four things: the line is high whenever the block is not busy; an accepted load produces a low start bit on the next cycle; the line and busy hold between ticks; and a released break is followed by a high, busy bit. Only the bench scenarios can show the rest. These are the exact bit contents of data frames, including parity, across word lengths, parity modes and tick periods; the cycle-exact bit widths; the repetition of break frames while the request is held; the request priority; and that a load during a break is dropped.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    localparam int WORD_MAX = 9;
    localparam int CNT_W    = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_STOP,
        S_MARK
    } tx_state_t;

    typedef enum logic [1:0] {
        K_DATA,
        K_IDLE,
        K_BREAK
    } frame_kind_t;
endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
    parameter int DIV_W = 8,
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [PRE_W-1:0] pre_div_i,
    input  logic [DIV_W-1:0] baud_div_i,
    output logic             tick_o
);
    logic [PRE_W-1:0] pre_cnt_q;
    logic [DIV_W-1:0] div_cnt_q;
    logic             pre_wrap;
    logic             div_wrap;

    assign pre_wrap = (pre_cnt_q == pre_div_i);
    assign div_wrap = (div_cnt_q == baud_div_i);
    assign tick_o   = run_i && pre_wrap && div_wrap;

    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            pre_cnt_q <= '0;
            div_cnt_q <= '0;
        end else if (pre_wrap) begin
            pre_cnt_q <= '0;
            if (div_wrap) div_cnt_q <= '0;
            else          div_cnt_q <= div_cnt_q + 1'b1;
        end else begin
            pre_cnt_q <= pre_cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sertx_parity.sv
module sertx_parity (
    input  logic [8:0] data_i,
    input  logic       len9_i,
    input  logic       par_en_i,
    input  logic       par_odd_i,
    output logic [8:0] word_o
);
    logic par8;
    logic par9;

    assign par8 = (^data_i[6:0]) ^ par_odd_i;
    assign par9 = (^data_i[7:0]) ^ par_odd_i;

    always_comb begin
        word_o = data_i;
        if (!len9_i) begin
            word_o[8] = 1'b1;
            if (par_en_i) word_o[7] = par8;
        end else if (par_en_i) begin
            word_o[8] = par9;
        end
    end
endmodule

// File: rtl/sertx_fsm.sv
module sertx_fsm
    import sertx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       load_i,
    input  logic [8:0] word_i,
    input  logic       len9_i,
    input  logic       idle_req_i,
    input  logic       brk_req_i,
    output logic       busy_o,
    output logic       txd_o
);
    tx_state_t          state_q, state_d;
    frame_kind_t        kind_q, start_kind;
    logic [8:0]         sh_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               len9_q;
    logic               go;
    logic [CNT_W-1:0]   last_pos;

    assign last_pos = len9_q ? CNT_W'(WORD_MAX - 1) : CNT_W'(WORD_MAX - 2);

    always_comb begin
        go         = 1'b0;
        start_kind = K_DATA;
        if (brk_req_i) begin
            go = 1'b1; start_kind = K_BREAK;
        end else if (idle_req_i) begin
            go = 1'b1; start_kind = K_IDLE;
        end else if (load_i) begin
            go = 1'b1; start_kind = K_DATA;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (go) state_d = S_START;
            S_START: if (tick_i) state_d = S_DATA;
            S_DATA:  if (tick_i && cnt_q == last_pos) state_d = S_STOP;
            S_STOP: begin
                if (tick_i) begin
                    if (kind_q == K_BREAK && brk_req_i) state_d = S_START;
                    else if (kind_q == K_BREAK)         state_d = S_MARK;
                    else                                state_d = S_IDLE;
                end
            end
            S_MARK:  if (tick_i) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            kind_q  <= K_DATA;
            sh_q    <= '1;
            cnt_q   <= '0;
            len9_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && go) begin
                kind_q <= start_kind;
                sh_q   <= word_i;
                len9_q <= len9_i;
            end
            if (state_q == S_START) begin
                cnt_q <= '0;
            end else if (state_q == S_DATA && tick_i) begin
                cnt_q <= cnt_q + 1'b1;
                sh_q  <= {1'b1, sh_q[8:1]};
            end
        end
    end

    always_comb begin
        busy_o = (state_q != S_IDLE);
        unique case (state_q)
            S_IDLE:  txd_o = 1'b1;
            S_START: txd_o = (kind_q == K_IDLE);
            S_DATA:  txd_o = (kind_q == K_DATA) ? sh_q[0] : (kind_q == K_IDLE);
            S_STOP:  txd_o = (kind_q != K_BREAK);
            S_MARK:  txd_o = 1'b1;
            default: txd_o = 1'b1;
        endcase
    end

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> txd_o); // R1
    AST_LOAD_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && load_i && !brk_req_i && !idle_req_i) |=> (busy_o && !txd_o)); // R2
    AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !tick_i) |=> $stable(txd_o)); // R10
    AST_MARK_AFTER_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STOP && kind_q == K_BREAK && tick_i && !brk_req_i) |=> (txd_o && busy_o)); // R7
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !tick_i) |=> busy_o); // R8
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DATA) |-> (cnt_q <= last_pos)); // R2
endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
    parameter int DIV_W = 8,
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [8:0]       data_i,
    input  logic             len9_i,
    input  logic             par_en_i,
    input  logic             par_odd_i,
    input  logic             idle_req_i,
    input  logic             brk_req_i,
    input  logic [PRE_W-1:0] pre_div_i,
    input  logic [DIV_W-1:0] baud_div_i,
    output logic             busy_o,
    output logic             txd_o
);
    logic       tick;
    logic [8:0] word;

    sertx_baud #(.DIV_W(DIV_W), .PRE_W(PRE_W)) u_baud (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (busy_o),
        .pre_div_i  (pre_div_i),
        .baud_div_i (baud_div_i),
        .tick_o     (tick)
    );

    sertx_parity u_par (
        .data_i    (data_i),
        .len9_i    (len9_i),
        .par_en_i  (par_en_i),
        .par_odd_i (par_odd_i),
        .word_o    (word)
    );

    sertx_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .load_i     (load_i),
        .word_i     (word),
        .len9_i     (len9_i),
        .idle_req_i (idle_req_i),
        .brk_req_i  (brk_req_i),
        .busy_o     (busy_o),
        .txd_o      (txd_o)
    );
endmodule

// File: tb/sim_sertx_top.sv
module sim_sertx_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_i = 1'b0;
    logic [8:0] data_i = '0;
    logic       len9_i = 1'b0;
    logic       par_en_i = 1'b0;
    logic       par_odd_i = 1'b0;
    logic       idle_req_i = 1'b0;
    logic       brk_req_i = 1'b0;
    logic [3:0] pre_div_i = '0;
    logic [7:0] baud_div_i = '0;
    logic       busy_o;
    logic       txd_o;
    int         nvec = 0;
    int         nfail = 0;

    always #4 clk = ~clk;

    sertx_top u0 (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .data_i(data_i),
        .len9_i(len9_i), .par_en_i(par_en_i), .par_odd_i(par_odd_i),
        .idle_req_i(idle_req_i), .brk_req_i(brk_req_i),
        .pre_div_i(pre_div_i), .baud_div_i(baud_div_i),
        .busy_o(busy_o), .txd_o(txd_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Checks n bit positions of p cycles each; pattern LSB = first bit. Clears load after the first cycle.
    task automatic expect_bits(input int n, input logic [15:0] pat, input int p, input string req);
        for (int b = 0; b < n; b++) begin
            bit ok = 1'b1;
            int act = pat[b];
            for (int c = 0; c < p; c++) begin
                if (ok && (txd_o !== pat[b] || busy_o !== 1'b1)) begin
                    ok = 1'b0;
                    act = (busy_o === 1'b1) ? int'(txd_o) : 2 + int'(txd_o);
                end
                @(negedge clk);
                load_i = 1'b0;
            end
            chk(ok, req, act, int'(pat[b]));
        end
    endtask

    task automatic expect_idle(input string req);
        chk(busy_o === 1'b0 && txd_o === 1'b1, req, {busy_o, txd_o}, 1);
    endtask

    task automatic send_data(input logic [8:0] d, input bit l9, input bit pe, input bit po,
                             input int pre, input int dv);
        int nb = l9 ? 9 : 8;
        int p = (pre + 1) * (dv + 1);
        logic [15:0] pat = '1;
        logic par = po;
        @(negedge clk);
        pre_div_i = 4'(pre); baud_div_i = 8'(dv);
        data_i = d; len9_i = l9; par_en_i = pe; par_odd_i = po; load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        // R2 capture: scramble mode inputs after acceptance
        data_i = ~d; len9_i = ~l9; par_en_i = ~pe; par_odd_i = ~po;
        pat[0] = 1'b0;
        for (int i = 0; i < nb; i++) pat[1 + i] = d[i];
        if (pe) begin
            for (int i = 0; i < nb - 1; i++) par ^= d[i];
            pat[nb] = par;   // R3
        end
        pat[nb + 1] = 1'b1;
        expect_bits(nb + 2, pat, p, pe ? "R3/R4 parity frame" : "R2/R4 data frame");
        expect_idle("R8 busy falls after stop");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_idle("R1 reset state");

        // R2/R3: exhaustive 8-bit words, even parity, one cycle per bit
        for (int d = 0; d < 256; d++) send_data(9'(d), 1'b0, 1'b1, 1'b0, 0, 0);

        // R2/R3/R4: sweep over periods, word lengths, parity modes
        for (int cfg = 0; cfg < 4; cfg++) begin
            int pre = (cfg == 2) ? 2 : (cfg == 3) ? 1 : 0;
            int dv  = (cfg == 1) ? 1 : (cfg == 3) ? 2 : 0;
            for (int l = 0; l < 2; l++)
                for (int pm = 0; pm < 3; pm++)
                    for (int k = 0; k < 40; k++)
                        send_data(9'((k * 37 + cfg * 11 + pm * 101) % 512), l[0],
                                  pm != 0, pm == 2, pre, dv);
        end

        // R9 + R6 + R7 + R8: break with load together, two frames, load during break ignored
        @(negedge clk);
        pre_div_i = 4'd1; baud_div_i = 8'd0; len9_i = 1'b0;
        brk_req_i = 1'b1; load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
        expect_bits(10, 16'h0000, 2, "R6/R9 break frame 1");
        brk_req_i = 1'b0;
        load_i = 1'b1;
        expect_bits(10, 16'h0000, 2, "R6 break frame 2");
        expect_bits(1, 16'h0001, 2, "R7 extra high bit");
        expect_idle("R8 load during break dropped");
        @(negedge clk);
        expect_idle("R8 still idle");

        // R6/R7: 9-bit break held for three frames, one cycle per bit
        @(negedge clk);
        pre_div_i = 4'd0; baud_div_i = 8'd0; len9_i = 1'b1; brk_req_i = 1'b1;
        @(negedge clk);
        len9_i = 1'b0;
        expect_bits(11, 16'h0000, 1, "R6 break 9-bit a");
        expect_bits(11, 16'h0000, 1, "R6 break 9-bit b");
        brk_req_i = 1'b0;
        expect_bits(11, 16'h0000, 1, "R6 break 9-bit c");
        expect_bits(1, 16'h0001, 1, "R7 extra bit 9-bit");
        expect_idle("R7 idle after mark");

        // R5/R9: idle frame with load together, 9-bit, period 3
        @(negedge clk);
        pre_div_i = 4'd2; len9_i = 1'b1; idle_req_i = 1'b1; load_i = 1'b1;
        @(negedge clk);
        idle_req_i = 1'b0; load_i = 1'b0;
        expect_bits(11, 16'hFFFF, 3, "R5/R9 idle frame 9-bit");
        expect_idle("R9 load dropped after idle");

        // R5: idle frame, 8-bit, period 2
        @(negedge clk);
        pre_div_i = 4'd0; baud_div_i = 8'd1; len9_i = 1'b0; idle_req_i = 1'b1;
        @(negedge clk);
        idle_req_i = 1'b0;
        expect_bits(10, 16'hFFFF, 2, "R5 idle frame 8-bit");
        expect_idle("R1 idle after idle frame");

        // R10 is also covered cycle by cycle inside expect_bits (every cycle of every bit)
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule